// File: doc/BRIEF.md
# Funnel Shift Unit

This block is a purely combinational funnel shifter for 32-bit operands. It treats a high word and a low word as a single double-width value and returns a 32-bit window cut out of it. The position of the window is set by a 5-bit amount. A direction input picks between a right funnel and a left funnel. A right funnel gives the low bits of the pair shifted right. A left funnel gives the high bits of the pair shifted left.

A 2-bit mode input decides which words feed the two halves of the pair. Funnel mode uses both input words as given. Rotate mode feeds the low input word into both halves, so that the window wraps around. Shift mode puts the low input word in one half and zeros in the other, which gives a plain logical shift.

Internally the pair is cut down to 63 bits, because a 32-bit window never needs all 64. That vector is built from three independently multiplexed pieces: an upper 31-bit piece, a single middle bit and a lower 31-bit piece. A chain of logarithmic stages then narrows the vector to the 32-bit window. Each stage is narrower than the one before it.

Top module: `fsh_top`

## Requirements
- R1: With `dir_left`=0 and `mode`=00, `result` equals bits [n+31:n] of the 64-bit value {`src_hi`,`src_lo`}, where n is `amt`.
- R2: With `dir_left`=1 and `mode`=00, `result` equals bits [63-n:32-n] of {`src_hi`,`src_lo`}, i.e. the upper word of that value shifted left by n.
- R3: When `amt`=0 in funnel mode, a right funnel returns `src_lo` unchanged and a left funnel returns `src_hi` unchanged.
- R4: With `mode`=01 and `dir_left`=0, `result` is `src_lo` rotated right by n, and `src_hi` has no effect on `result`.
- R5: With `mode`=01 and `dir_left`=1, `result` is `src_lo` rotated left by n, and `src_hi` has no effect on `result`.
- R6: With `mode`=10 and `dir_left`=0, `result` is `src_lo` shifted right by n with zeros entering at the top, and `src_hi` has no effect on `result`.
- R7: With `mode`=10 and `dir_left`=1, `result` is `src_lo` shifted left by n with zeros entering at the bottom, and `src_hi` has no effect on `result`.
- R8: `mode`=11 behaves exactly like funnel mode 00 in both directions.
- R9: `result` depends only on the present inputs. It is updated within the same time step as any input change, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_hi | input | 32 | Upper word of the funnel pair (funnel modes only) |
| src_lo | input | 32 | Lower word of the funnel pair; the data word in rotate and shift modes |
| amt | input | 5 | Shift or rotate distance n, 0 to 31 |
| dir_left | input | 1 | 0 selects right, 1 selects left |
| mode | input | 2 | 00 funnel, 01 rotate, 10 logical shift, 11 funnel |
| result | output | 32 | Extracted 32-bit window |

## Verification
The bench targets the mirrored indexing of the left path at amounts 0 and 31. A design that reuses the right-path offset there returns the wrong word at 0 and a wrongly aligned window at 31. Rotations are probed with words whose top and bottom bits differ. Slicing off the wrong bit of the lower half in rotate mode shows up as a single wrong wrap-around bit. In rotate and shift modes, every vector is applied a second time with a different `src_hi`. A design that leaks the high word into the unused half changes its output between the two runs. Constrained random vectors over all four mode codes cover the remaining window positions.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int FSH_DW = 32;

    typedef enum logic [1:0] {
        FSH_FUNNEL     = 2'b00,
        FSH_ROTATE     = 2'b01,
        FSH_SHIFT      = 2'b10,
        FSH_FUNNEL_ALT = 2'b11
    } fsh_mode_e;

    typedef struct packed {
        logic      left;
        fsh_mode_e mode;
    } fsh_ctrl_t;

    // Width of the vector entering stage s of the narrowing chain.
    function automatic int stage_in_width(input int dw, input int s);
        return 2 * dw - (1 << s);
    endfunction

    // Width of the vector leaving stage s.
    function automatic int stage_out_width(input int dw, input int s);
        return 2 * dw - (2 << s);
    endfunction

endpackage

// File: rtl/fsh_source.sv
module fsh_source
    import fsh_pkg::*;
#(
    parameter int DW = FSH_DW
) (
    input  logic [DW-1:0] src_hi,
    input  logic [DW-1:0] src_lo,
    input  fsh_ctrl_t     ctrl,
    output logic [DW-1:0] half_hi,
    output logic [DW-1:0] half_lo
);

    always_comb begin
        unique case (ctrl.mode)
            FSH_ROTATE: begin
                half_hi = src_lo;
                half_lo = src_lo;
            end
            FSH_SHIFT: begin
                if (ctrl.left) begin
                    half_hi = src_lo;
                    half_lo = '0;
                end else begin
                    half_hi = '0;
                    half_lo = src_lo;
                end
            end
            default: begin
                half_hi = src_hi;
                half_lo = src_lo;
            end
        endcase
    end

endmodule

// File: rtl/fsh_pieces.sv
module fsh_pieces
    import fsh_pkg::*;
#(
    parameter int DW = FSH_DW,
    localparam int CW = 2 * DW - 1,
    localparam int PW = DW - 1
) (
    input  logic [DW-1:0] half_hi,
    input  logic [DW-1:0] half_lo,
    input  logic          left,
    output logic [CW-1:0] cat
);

    logic [PW-1:0] piece_top;
    logic          piece_mid;
    logic [PW-1:0] piece_bot;

    // Upper piece: only ever sourced from the high half.
    always_comb begin
        if (left) piece_top = half_hi[DW-1:1];
        else      piece_top = half_hi[DW-2:0];
    end

    // Middle bit: the one position where the two halves meet.
    always_comb begin
        if (left) piece_mid = half_hi[0];
        else      piece_mid = half_lo[DW-1];
    end

    // Lower piece: only ever sourced from the low half.
    always_comb begin
        if (left) piece_bot = half_lo[DW-1:1];
        else      piece_bot = half_lo[DW-2:0];
    end

    assign cat = {piece_top, piece_mid, piece_bot};

endmodule

// File: rtl/fsh_window.sv
module fsh_window
    import fsh_pkg::*;
#(
    parameter int DW = FSH_DW,
    localparam int AW = $clog2(DW),
    localparam int CW = 2 * DW - 1
) (
    input  logic [CW-1:0] cat,
    input  logic [AW-1:0] ofs,
    output logic [DW-1:0] win
);

    for (genvar s = 0; s < AW; s++) begin : stg
        localparam int WI = stage_in_width(DW, s);
        localparam int WO = stage_out_width(DW, s);
        logic [WI-1:0] din;
        logic [WO-1:0] dout;
        if (s == 0) begin : g_first
            assign din = cat;
        end else begin : g_chain
            assign din = stg[s-1].dout;
        end
        assign dout = ofs[s] ? din[WI-1 -: WO] : din[WO-1:0];
    end

    assign win = stg[AW-1].dout;

    always_comb begin
        if (ofs == '0) begin
            // R3
            zero_ofs_chk: assert (win == cat[DW-1:0])
                else $error("window at offset 0 is not the bottom slice");
        end
        if (ofs == '1) begin
            // R2
            full_ofs_chk: assert (win == cat[CW-1 -: DW])
                else $error("window at top offset is not the top slice");
        end
    end

endmodule

// File: rtl/fsh_top.sv
module fsh_top
    import fsh_pkg::*;
#(
    parameter int DW = FSH_DW,
    localparam int AW = $clog2(DW),
    localparam int CW = 2 * DW - 1
) (
    input  logic [DW-1:0] src_hi,
    input  logic [DW-1:0] src_lo,
    input  logic [AW-1:0] amt,
    input  logic          dir_left,
    input  logic [1:0]    mode,
    output logic [DW-1:0] result
);

    fsh_ctrl_t     ctrl;
    logic [DW-1:0] half_hi;
    logic [DW-1:0] half_lo;
    logic [CW-1:0] cat;
    logic [AW-1:0] ofs;

    assign ctrl.left = dir_left;
    assign ctrl.mode = fsh_mode_e'(mode);

    // A left window ends n bits below the top of the 63-bit vector,
    // so its start offset is the bitwise complement of n.
    assign ofs = dir_left ? ~amt : amt;

    fsh_source #(.DW(DW)) u_source (
        .src_hi (src_hi),
        .src_lo (src_lo),
        .ctrl   (ctrl),
        .half_hi(half_hi),
        .half_lo(half_lo)
    );

    fsh_pieces #(.DW(DW)) u_pieces (
        .half_hi(half_hi),
        .half_lo(half_lo),
        .left   (ctrl.left),
        .cat    (cat)
    );

    fsh_window #(.DW(DW)) u_window (
        .cat(cat),
        .ofs(ofs),
        .win(result)
    );

    always_comb begin
        if (ctrl.mode == FSH_ROTATE) begin
            // R4 R5
            rot_pieces_chk: assert (cat[CW-1:DW] == cat[DW-2:0])
                else $error("rotate pieces differ");
            // R4
            rot_zero_chk: assert (!(amt == '0) || result == src_lo)
                else $error("rotate by zero altered the word");
        end
        if (ctrl.mode == FSH_SHIFT && !dir_left) begin
            // R6
            shr_fill_chk: assert (cat[CW-1:DW] == '0)
                else $error("right shift upper piece not zero");
        end
        if (ctrl.mode == FSH_SHIFT && dir_left) begin
            // R7
            shl_fill_chk: assert (cat[DW-2:0] == '0)
                else $error("left shift lower piece not zero");
        end
        if ((ctrl.mode == FSH_FUNNEL || ctrl.mode == FSH_FUNNEL_ALT) && amt == '0) begin
            // R3
            funnel_zero_chk: assert (result == (dir_left ? src_hi : src_lo))
                else $error("zero-distance funnel returned wrong word");
        end
    end

endmodule

// File: tb/fsh_top_test.sv
`timescale 1ns/1ps
module fsh_top_test;

    logic        clk = 1'b0;
    logic [31:0] src_hi, src_lo;
    logic [4:0]  amt;
    logic        dir_left;
    logic [1:0]  mode;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fsh_top uut (
        .src_hi  (src_hi),
        .src_lo  (src_lo),
        .amt     (amt),
        .dir_left(dir_left),
        .mode    (mode),
        .result  (result)
    );

    function automatic logic [31:0] model(input logic [31:0] h, input logic [31:0] l,
                                          input logic [4:0] n, input logic lf,
                                          input logic [1:0] md);
        logic [63:0] pair;
        logic [63:0] r;
        case (md)
            2'b01:   pair = {l, l};
            2'b10:   pair = lf ? {l, 32'h0} : {32'h0, l};
            default: pair = {h, l};
        endcase
        if (lf) begin
            r = pair << n;
            return r[63:32];
        end else begin
            r = pair >> n;
            return r[31:0];
        end
    endfunction

    function automatic string req_of(input logic lf, input logic [1:0] md);
        case (md)
            2'b01:   return lf ? "R5" : "R4";
            2'b10:   return lf ? "R7" : "R6";
            2'b11:   return "R8";
            default: return lf ? "R2" : "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h (hi=%08h lo=%08h n=%0d left=%0b mode=%0d)",
                     req, got, exp, src_hi, src_lo, amt, dir_left, mode);
        end
    endtask

    task automatic apply(input logic [31:0] h, input logic [31:0] l, input logic [4:0] n,
                         input logic lf, input logic [1:0] md, input string req);
        @(negedge clk);
        src_hi = h; src_lo = l; amt = n; dir_left = lf; mode = md;
        #1;
        check(req, result, model(h, l, n, lf, md));
    endtask

    // For modes where the high word must not matter, rerun with another high word.
    task automatic apply_ignore(input logic [31:0] l, input logic [4:0] n,
                                input logic lf, input logic [1:0] md, input string req);
        logic [31:0] first;
        apply(32'h0000_0000, l, n, lf, md, req);
        first = result;
        @(negedge clk);
        src_hi = 32'hFFFF_FFFF;
        #1;
        check(req, result, first);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        src_hi = '0; src_lo = '0; amt = '0; dir_left = 1'b0; mode = 2'b00;
        #1;
        // R9: result follows inputs with no clock edge
        check("R9", result, 32'h0);
        src_lo = 32'h1357_9BDF;
        #1;
        check("R9", result, 32'h1357_9BDF);

        // R3: zero distance
        apply(32'hDEAD_BEEF, 32'h0123_4567, 5'd0, 1'b0, 2'b00, "R3");
        check("R3", result, 32'h0123_4567);
        apply(32'hDEAD_BEEF, 32'h0123_4567, 5'd0, 1'b1, 2'b00, "R3");
        check("R3", result, 32'hDEAD_BEEF);

        // R1 / R2 edges of the window
        apply(32'h8000_0001, 32'h8000_0001, 5'd31, 1'b0, 2'b00, "R1");
        apply(32'h8000_0001, 32'h8000_0001, 5'd31, 1'b1, 2'b00, "R2");
        apply(32'hA5A5_A5A5, 32'h5A5A_5A5A, 5'd1, 1'b1, 2'b00, "R2");
        apply(32'hA5A5_A5A5, 32'h5A5A_5A5A, 5'd16, 1'b0, 2'b00, "R1");

        // R4 / R5 rotations with distinct end bits
        apply(32'h0, 32'h8000_0001, 5'd1, 1'b0, 2'b01, "R4");
        check("R4", result, 32'hC000_0000);
        apply(32'h0, 32'h8000_0001, 5'd1, 1'b1, 2'b01, "R5");
        check("R5", result, 32'h0000_0003);
        apply(32'h0, 32'h1234_5678, 5'd0, 1'b1, 2'b01, "R5");
        apply(32'h0, 32'h1234_5678, 5'd31, 1'b0, 2'b01, "R4");

        // R6 / R7 logical shifts
        apply(32'h0, 32'hFFFF_FFFF, 5'd31, 1'b0, 2'b10, "R6");
        check("R6", result, 32'h0000_0001);
        apply(32'h0, 32'hFFFF_FFFF, 5'd31, 1'b1, 2'b10, "R7");
        check("R7", result, 32'h8000_0000);

        // R8: mode 11 equals funnel
        apply(32'hCAFE_F00D, 32'h1111_2222, 5'd7, 1'b0, 2'b11, "R8");
        apply(32'hCAFE_F00D, 32'h1111_2222, 5'd7, 1'b1, 2'b11, "R8");

        // High word ignored in rotate and shift modes
        for (int n = 0; n < 32; n += 5) begin
            apply_ignore(32'h9E37_79B9, 5'(n), 1'b0, 2'b01, "R4");
            apply_ignore(32'h9E37_79B9, 5'(n), 1'b1, 2'b01, "R5");
            apply_ignore(32'h9E37_79B9, 5'(n), 1'b0, 2'b10, "R6");
            apply_ignore(32'h9E37_79B9, 5'(n), 1'b1, 2'b10, "R7");
        end

        // Constrained random sweep over all modes and directions
        for (int i = 0; i < 800; i++) begin
            logic [31:0] h = $urandom;
            logic [31:0] l = $urandom;
            logic [4:0]  n = 5'($urandom_range(0, 31));
            logic        lf = 1'($urandom);
            logic [1:0]  md = 2'($urandom);
            if (i % 8 == 0) n = (i % 16 == 0) ? 5'd0 : 5'd31;
            apply(h, l, n, lf, md, req_of(lf, md));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule